// File: doc/BRIEF.md
# Sectioned Strip Hit Sparsifier and Time-Ordered Concentrator

This block turns a wide vector of matched strip hits into a compact stream of hit words. Only strips that carry a hit produce a word. The strips are split into equal sections, and each section has a priority encoder that emits one hit per clock into a small FIFO for that section. A concentrator looks at the heads of all non-empty FIFOs and takes the hit with the oldest time stamp. Because the wrap-around compare is modulo the time-stamp range, hits leave in time order even when sections drain at different speeds. A serializer frames each selected hit, or an idle word when none is waiting, and spreads the bits over one to four output lanes at the readout clock.

The source presents a hit vector together with its time stamp and per-strip amplitudes, and asserts a load strobe. A vector is taken only while every section has finished encoding its previous vector. Words already held in the FIFOs keep draining while later vectors are encoded.

Top module: `strip_hit_compactor`

## Requirements
- R1: After reset `load_ready` is 1 and the lanes carry only idle words, whose valid bit is 0. `frame_start` is high on the first beat of every word.
- R2: Each strip whose bit is set in an accepted `hit_vec` yields exactly one valid word. Strips that are clear yield none, so an all-zero vector produces no valid word.
- R3: A section encodes at most one hit per clock, always its lowest-numbered pending strip. If a vector has n hits in one section and that section's FIFO has room, `load_ready` returns to 1 exactly n clocks after the edge that accepts the vector.
- R4: A word is 27 bits wide. Bits 26:20 hold the strip number, 19:11 the time stamp, bit 10 the valid flag (1 for a hit), 9:6 `chip_id` and 5:2 the 4-bit amplitude of that strip (taken from `amp_vec[4*s +: 4]`). Bits 1:0 are 0. An idle word is 0 except for `chip_id`.
- R5: Among non-empty FIFOs, the one whose head is oldest goes out first. Time stamp a is older than b when (b - a) mod 512 lies in 1..255, so 510 is older than 2.
- R6: When head time stamps are equal, the lowest section index wins. As a result, one accepted vector comes out in ascending strip order.
- R7: `lane_sel` + 1 lanes are used, and the value is sampled at each word boundary. Word bit 26-i goes out on lane i mod L in beat i/L of the word. A word lasts ceil(27/L) clocks (27, 14, 9 or 7). Unused lanes and unused slots carry 0.
- R8: `hit_load` while `load_ready` is 0 is ignored.
- R9: When a section's FIFO is full, its encoder stalls and no hit is lost, even with more hits in one section than FIFO entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_load | input | 1 | Strobe: present a new hit vector |
| hit_ts | input | 9 | Time stamp of the presented vector |
| hit_vec | input | 128 | One bit per strip, 1 = hit |
| amp_vec | input | 512 | 4-bit amplitude per strip, strip s at bits 4s+3:4s |
| chip_id | input | 4 | Chip address inserted into every word |
| lane_sel | input | 2 | Number of active lanes minus one |
| load_ready | output | 1 | All sections idle; a load is accepted |
| ser_out | output | 4 | Serial lanes |
| frame_start | output | 1 | High in the first beat of each word |

## Verification
The hardest case to reach is the time-order merge. It only matters when FIFOs hold different time stamps at the same moment. From the ports, that requires a second vector to be accepted while words from the first are still queued. The bench loads a vector with hits only in high sections, waits for `load_ready`, and at once loads a later-stamped vector with hits in section 0. It repeats this with the stamp wrapping from 510 to 2. A lowest-section or plain-magnitude merge would emit the second vector's hits early. FIFO back-pressure is reached by putting twelve hits into one section with two lanes, so the 8-entry FIFO fills and the encoder must stall. A load strobe is driven during that stall.

// File: rtl/strip_cmp_pkg.sv
package strip_cmp_pkg;

    localparam int STRIP_W = 7;
    localparam int TS_W    = 9;
    localparam int CHIP_W  = 4;
    localparam int AMP_W   = 4;
    localparam int SPARE_W = 2;
    localparam int WORD_W  = STRIP_W + TS_W + 1 + CHIP_W + AMP_W + SPARE_W;

    typedef struct packed {
        logic [STRIP_W-1:0] strip;
        logic [TS_W-1:0]    ts;
        logic [AMP_W-1:0]   amp;
    } hit_entry_t;

    // a older than b when (b - a) mod 2^TS_W lies in the lower half, non-zero
    function automatic logic ts_older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
        logic [TS_W-1:0] diff;
        diff = b - a;
        return (diff != '0) && !diff[TS_W-1];
    endfunction

endpackage

// File: rtl/hit_sparsifier.sv
module hit_sparsifier
    import strip_cmp_pkg::*;
#(
    parameter int SEC_STRIPS = 32,
    parameter int SEC_BASE   = 0,
    localparam int IDX_W     = $clog2(SEC_STRIPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [SEC_STRIPS-1:0]       slice_hits,
    input  logic [SEC_STRIPS*AMP_W-1:0] slice_amp,
    input  logic [TS_W-1:0]             load_ts,
    input  logic                        fifo_full,
    output logic                        push,
    output hit_entry_t                  push_data,
    output logic                        idle
);

    typedef struct packed {
        logic [SEC_STRIPS-1:0]       pending;
        logic [TS_W-1:0]             ts;
        logic [SEC_STRIPS*AMP_W-1:0] amp;
    } spars_state_t;

    spars_state_t st_d, st_q;
    logic [IDX_W-1:0] sel_idx;
    logic             any_hit;

    always_comb begin
        sel_idx = '0;
        any_hit = 1'b0;
        // scan downward so the lowest set bit is the last one kept
        for (int i = SEC_STRIPS - 1; i >= 0; i--) begin
            if (st_q.pending[i]) begin
                sel_idx = IDX_W'(i);
                any_hit = 1'b1;
            end
        end

        push            = any_hit && !fifo_full;
        push_data.strip = STRIP_W'(SEC_BASE) + STRIP_W'(sel_idx);
        push_data.ts    = st_q.ts;
        push_data.amp   = st_q.amp[sel_idx*AMP_W +: AMP_W];
        idle            = (st_q.pending == '0);

        st_d = st_q;
        if (push) begin
            st_d.pending[sel_idx] = 1'b0;
        end
        if (load) begin
            st_d.pending = slice_hits;
            st_d.ts      = load_ts;
            st_d.amp     = slice_amp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !fifo_full && st_q.pending != '0) |=>
        ($countones(st_q.pending) + 1 == $countones($past(st_q.pending))))
        else $error("encoder cleared other than one hit"); // R3

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && fifo_full) |=> $stable(st_q.pending))
        else $error("hit lost while fifo full"); // R9

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> idle)
        else $error("load reached a busy section"); // R8

endmodule

// File: rtl/hit_fifo.sv
module hit_fifo
    import strip_cmp_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  hit_entry_t push_data,
    input  logic       pop,
    output hit_entry_t head,
    output logic       full,
    output logic       empty
);

    typedef struct packed {
        hit_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       wr;
        logic [PTR_W-1:0]       rd;
        logic [CNT_W-1:0]       cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    always_comb begin
        full  = (st_q.cnt == CNT_W'(DEPTH));
        empty = (st_q.cnt == '0);
        head  = st_q.mem[st_q.rd];

        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("push into full fifo"); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("pop from empty fifo"); // R6

endmodule

// File: rtl/ts_concentrator.sv
module ts_concentrator
    import strip_cmp_pkg::*;
#(
    parameter int NUM_SEC = 4,
    localparam int SEL_W  = $clog2(NUM_SEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  hit_entry_t         heads [NUM_SEC],
    input  logic [NUM_SEC-1:0] empty,
    input  logic               take,
    output logic [NUM_SEC-1:0] pop,
    output logic               have,
    output hit_entry_t         chosen
);

    logic [SEL_W-1:0] best;

    always_comb begin
        have = 1'b0;
        best = '0;
        // strict compare keeps the lower index on a tie
        for (int i = 0; i < NUM_SEC; i++) begin
            if (!empty[i]) begin
                if (!have || ts_older(heads[i].ts, heads[best].ts)) begin
                    best = SEL_W'(i);
                end
                have = 1'b1;
            end
        end
        chosen = heads[best];
        pop    = '0;
        if (take && have) begin
            pop[best] = 1'b1;
        end
    end

    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop))
        else $error("more than one section popped"); // R6

    for (genvar gi = 0; gi < NUM_SEC; gi++) begin : g_age_i
        for (genvar gj = 0; gj < NUM_SEC; gj++) begin : g_age_j
            if (gi != gj) begin : g_pair
                AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                    (pop[gi] && !empty[gj]) |->
                    !ts_older(heads[gj].ts, heads[gi].ts))
                    else $error("younger hit popped before older one"); // R5
            end
        end
    end

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
    import strip_cmp_pkg::*;
#(
    parameter int MAX_LANES = 4,
    localparam int LSEL_W   = $clog2(MAX_LANES),
    localparam int LCNT_W   = LSEL_W + 1,
    localparam int BEAT_W   = $clog2(WORD_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LSEL_W-1:0]    lane_sel,
    input  logic [CHIP_W-1:0]    chip_id,
    input  logic                 have,
    input  hit_entry_t           chosen,
    output logic                 take,
    output logic [MAX_LANES-1:0] ser_out,
    output logic                 frame_start
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BEAT_W-1:0] beat;
        logic [LCNT_W-1:0] lanes;
    } ser_state_t;

    ser_state_t st_d, st_q;

    function automatic logic [BEAT_W-1:0] beats_for(input logic [LCNT_W-1:0] n);
        return BEAT_W'((WORD_W + int'(n) - 1) / int'(n));
    endfunction

    always_comb begin
        take = (st_q.beat == beats_for(st_q.lanes) - 1'b1);

        st_d      = st_q;
        st_d.beat = st_q.beat + 1'b1;
        if (take) begin
            st_d.beat  = '0;
            st_d.lanes = LCNT_W'(lane_sel) + 1'b1;
            if (have) begin
                st_d.word = {chosen.strip, chosen.ts, 1'b1, chip_id, chosen.amp,
                             {SPARE_W{1'b0}}};
            end else begin
                st_d.word = {{STRIP_W{1'b0}}, {TS_W{1'b0}}, 1'b0, chip_id,
                             {AMP_W{1'b0}}, {SPARE_W{1'b0}}};
            end
        end
    end

    always_comb begin
        frame_start = (st_q.beat == '0);
        for (int l = 0; l < MAX_LANES; l++) begin
            int idx;
            int pos;
            idx = int'(st_q.beat) * int'(st_q.lanes) + l;
            pos = (idx < WORD_W) ? (WORD_W - 1 - idx) : 0;
            ser_out[l] = (l < int'(st_q.lanes) && idx < WORD_W) ? st_q.word[pos] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word  <= '0;
            st_q.beat  <= '0;
            st_q.lanes <= LCNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start)
        else $error("word shorter than two beats"); // R7

endmodule

// File: rtl/strip_hit_compactor.sv
module strip_hit_compactor
    import strip_cmp_pkg::*;
#(
    parameter int NUM_STRIPS   = 128,
    parameter int NUM_SECTIONS = 4,
    parameter int FIFO_DEPTH   = 8,
    parameter int MAX_LANES    = 4,
    localparam int SEC_STRIPS  = NUM_STRIPS / NUM_SECTIONS,
    localparam int LSEL_W      = $clog2(MAX_LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit_load,
    input  logic [TS_W-1:0]             hit_ts,
    input  logic [NUM_STRIPS-1:0]       hit_vec,
    input  logic [NUM_STRIPS*AMP_W-1:0] amp_vec,
    input  logic [CHIP_W-1:0]           chip_id,
    input  logic [LSEL_W-1:0]           lane_sel,
    output logic                        load_ready,
    output logic [MAX_LANES-1:0]        ser_out,
    output logic                        frame_start
);

    logic [NUM_SECTIONS-1:0] sec_idle;
    logic [NUM_SECTIONS-1:0] sec_push;
    logic [NUM_SECTIONS-1:0] sec_full;
    logic [NUM_SECTIONS-1:0] sec_empty;
    logic [NUM_SECTIONS-1:0] sec_pop;
    hit_entry_t              sec_data [NUM_SECTIONS];
    hit_entry_t              sec_head [NUM_SECTIONS];
    logic                    sec_load;
    logic                    take;
    logic                    have;
    hit_entry_t              chosen;

    assign load_ready = &sec_idle;
    assign sec_load   = hit_load && load_ready;

    for (genvar g = 0; g < NUM_SECTIONS; g++) begin : g_sec
        hit_sparsifier #(
            .SEC_STRIPS (SEC_STRIPS),
            .SEC_BASE   (g * SEC_STRIPS)
        ) i_spars (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (sec_load),
            .slice_hits (hit_vec[g*SEC_STRIPS +: SEC_STRIPS]),
            .slice_amp  (amp_vec[g*SEC_STRIPS*AMP_W +: SEC_STRIPS*AMP_W]),
            .load_ts    (hit_ts),
            .fifo_full  (sec_full[g]),
            .push       (sec_push[g]),
            .push_data  (sec_data[g]),
            .idle       (sec_idle[g])
        );

        hit_fifo #(
            .DEPTH (FIFO_DEPTH)
        ) i_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (sec_push[g]),
            .push_data (sec_data[g]),
            .pop       (sec_pop[g]),
            .head      (sec_head[g]),
            .full      (sec_full[g]),
            .empty     (sec_empty[g])
        );
    end

    ts_concentrator #(
        .NUM_SEC (NUM_SECTIONS)
    ) i_conc (
        .clk    (clk),
        .rst_n  (rst_n),
        .heads  (sec_head),
        .empty  (sec_empty),
        .take   (take),
        .pop    (sec_pop),
        .have   (have),
        .chosen (chosen)
    );

    lane_serializer #(
        .MAX_LANES (MAX_LANES)
    ) i_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_sel    (lane_sel),
        .chip_id     (chip_id),
        .have        (have),
        .chosen      (chosen),
        .take        (take),
        .ser_out     (ser_out),
        .frame_start (frame_start)
    );

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_load && load_ready && hit_vec != '0) |=> !load_ready)
        else $error("accepted vector did not occupy a section"); // R8

endmodule

// File: tb/test_strip_hit_compactor.sv
module test_strip_hit_compactor;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] CHIP = 4'hA;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hit_load = 1'b0;
    logic [8:0]   hit_ts = '0;
    logic [127:0] hit_vec = '0;
    logic [511:0] amp_vec;
    logic [3:0]   chip_id = CHIP;
    logic [1:0]   lane_sel = 2'd0;
    logic         load_ready;
    logic [3:0]   ser_out;
    logic         frame_start;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strip_hit_compactor i_strip_hit_compactor (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_load    (hit_load),
        .hit_ts      (hit_ts),
        .hit_vec     (hit_vec),
        .amp_vec     (amp_vec),
        .chip_id     (chip_id),
        .lane_sel    (lane_sel),
        .load_ready  (load_ready),
        .ser_out     (ser_out),
        .frame_start (frame_start)
    );

    function automatic logic [3:0] amp_of(input int s);
        return 4'((s * 5 + 3) % 16);
    endfunction

    // ---------------- lane monitor: rebuilds words from the lanes ----------
    int          mb = 0;
    int          ml = 1;
    logic [26:0] mw = '0;
    logic [26:0] cap [64];
    int          ncap = 0;
    int          nidle = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start) begin
                mb = 0;
                ml = int'(lane_sel) + 1;
                mw = '0;
            end
            for (int l = 0; l < 4; l++) begin
                if (l < ml && mb * ml + l < 27) mw[26 - (mb * ml + l)] = ser_out[l];
            end
            mb++;
            if (mb * ml >= 27 && (mb - 1) * ml < 27) begin
                if (mw[10]) begin
                    if (ncap < 64) cap[ncap] = mw;
                    ncap++;
                end else begin
                    nidle++;
                end
            end
        end
    end

    // ---------------- helpers --------------------------------------------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic flush();
        @(posedge clk);
        ncap  = 0;
        nidle = 0;
    endtask

    task automatic do_load(input logic [127:0] v, input logic [8:0] ts);
        while (!load_ready) @(negedge clk);
        hit_vec  = v;
        hit_ts   = ts;
        hit_load = 1'b1;
        @(negedge clk);
        hit_load = 1'b0;
    endtask

    task automatic wait_words(input int n);
        for (int c = 0; c < 4000 && ncap < n; c++) @(negedge clk);
    endtask

    task automatic expect_word(input int k, input int strip, input int ts, input string req);
        logic [26:0] e;
        e = {7'(strip), 9'(ts), 1'b1, CHIP, amp_of(strip), 2'b00};
        if (k >= ncap) check(1'b0, req, 0, int'(e));
        else           check(cap[k] == e, req, int'(cap[k]), int'(e));
    endtask

    task automatic set_lanes(input int s);
        @(negedge clk);
        lane_sel = 2'(s);
        repeat (80) @(negedge clk);
        flush();
    endtask

    // ---------------- scenarios ---------------------------------------------
    task automatic t_reset();
        check(load_ready === 1'b1, "R1 load_ready after reset", int'(load_ready), 1);
        repeat (70) @(negedge clk);
        check(ncap == 0, "R1 no valid word after reset", ncap, 0);
        check(nidle > 0, "R1 idle words flow", nidle, 1);
    endtask

    task automatic t_basic();
        logic [127:0] v;
        int exp_s [6] = '{0, 5, 40, 77, 96, 127};
        set_lanes(0);
        v = '0;
        v[5] = 1; v[40] = 1; v[77] = 1; v[127] = 1; v[0] = 1; v[96] = 1;
        do_load(v, 9'd100);
        wait_words(6);
        for (int k = 0; k < 6; k++) expect_word(k, exp_s[k], 100, "R2 R4 R6 ascending single-lane word");
        repeat (200) @(negedge clk);
        check(ncap == 6, "R2 no extra words", ncap, 6);
    endtask

    task automatic t_empty();
        flush();
        do_load('0, 9'd50);
        check(load_ready === 1'b1, "R2 empty vector leaves ready", int'(load_ready), 1);
        repeat (150) @(negedge clk);
        check(ncap == 0, "R2 empty vector gives no word", ncap, 0);
    endtask

    task automatic t_rate();
        logic [127:0] v;
        int k;
        set_lanes(3);
        v = '0;
        v[33] = 1; v[34] = 1; v[40] = 1; v[50] = 1; v[63] = 1;
        do_load(v, 9'd200);
        k = 0;
        while (!load_ready && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(k == 5, "R3 one hit encoded per clock", k, 5);
        wait_words(5);
        expect_word(0, 33, 200, "R3 lowest strip first");
        expect_word(4, 63, 200, "R3 highest strip last");
    endtask

    task automatic t_stall();
        logic [127:0] v;
        logic [127:0] w;
        set_lanes(1);
        v = '0;
        for (int s = 0; s < 12; s++) v[s] = 1'b1;
        do_load(v, 9'd7);
        check(load_ready === 1'b0, "R8 busy after load", int'(load_ready), 0);
        w = '0;
        w[100] = 1'b1;
        hit_vec  = w;
        hit_ts   = 9'd8;
        hit_load = 1'b1;
        @(negedge clk);
        hit_load = 1'b0;
        wait_words(12);
        for (int k = 0; k < 12; k++) expect_word(k, k, 7, "R9 no hit lost through full fifo");
        repeat (300) @(negedge clk);
        check(ncap == 12, "R8 load while busy ignored", ncap, 12);
    endtask

    task automatic t_order();
        logic [127:0] a;
        logic [127:0] b;
        set_lanes(3);
        a = '0; a[70] = 1; a[120] = 1; a[121] = 1;
        b = '0; b[1] = 1; b[2] = 1; b[33] = 1;
        do_load(a, 9'd20);
        do_load(b, 9'd21);
        wait_words(6);
        expect_word(0, 70, 20, "R5 older vector first");
        expect_word(1, 120, 20, "R5 older vector first");
        expect_word(2, 121, 20, "R5 older vector first");
        expect_word(3, 1, 21, "R5 newer vector after");
        expect_word(5, 33, 21, "R5 newer vector after");
    endtask

    task automatic t_wrap();
        logic [127:0] a;
        logic [127:0] b;
        flush();
        a = '0; a[80] = 1; a[81] = 1;
        b = '0; b[3] = 1;
        do_load(a, 9'd510);
        do_load(b, 9'd2);
        wait_words(3);
        expect_word(0, 80, 510, "R5 stamp 510 older than 2");
        expect_word(1, 81, 510, "R5 stamp 510 older than 2");
        expect_word(2, 3, 2, "R5 wrapped stamp last");
    endtask

    task automatic t_lanes();
        int exp_p [4] = '{27, 14, 9, 7};
        logic [127:0] v;
        for (int s = 0; s < 4; s++) begin
            int p;
            set_lanes(s);
            while (!frame_start) @(negedge clk);
            @(negedge clk);
            p = 1;
            while (!frame_start && p < 100) begin
                @(negedge clk);
                p++;
            end
            check(p == exp_p[s], "R7 word length per lane count", p, exp_p[s]);
        end
        set_lanes(2);
        v = '0;
        v[64] = 1'b1;
        do_load(v, 9'd300);
        wait_words(1);
        expect_word(0, 64, 300, "R7 three-lane striping");
        check(ser_out[3] === 1'b0, "R7 unused lane low", int'(ser_out[3]), 0);
    endtask

    // ---------------- watchdog ----------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- main --------------------------------------------------
    initial begin
        for (int s = 0; s < 128; s++) amp_vec[s*4 +: 4] = amp_of(s);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_empty();
        t_rate();
        t_stall();
        t_order();
        t_wrap();
        t_lanes();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule